// File: doc/BRIEF.md
# SPI Slave with Command-Addressed Registers

This block is a serial peripheral interface slave. It gives an external master access to three registers: a receive register, a transmit register and a status register. Every transaction opens with a command byte. One field of that byte says where the following MOSI bytes go, and another field says which register is returned on MISO. A single transaction can carry any number of data bytes after the command. Clock polarity and clock phase are chosen by parameter, so any of the four common SPI modes can be built.

On the user side the block gives the last received byte, a port that loads the transmit register, acknowledge input for the receive register, three status flags and three interrupt pins. The SPI inputs pass through synchronizers into the system clock domain. The system clock must run at least four times as fast as the serial clock, with enough margin for the synchronizer delay.

The transfer sequencer has three named states. ST_IDLE moves to ST_CMD when select is seen low. ST_CMD moves to ST_DATA on the eighth sample edge, which completes the command byte. ST_CMD and ST_DATA both return to ST_IDLE when select is seen high.

Top module: `spi_cmd_regs`

## Requirements
- R1: While select is high, SCLK and MOSI have no effect on any register or flag. The MISO enable output is 0, and MISO reads 0.
- R2: The first byte after select falls is a command, received MSB first. Bits [5:4] are the write address and bits [3:2] are the read address. Bits [7:6] and [1:0] are ignored.
- R3: Read addresses select these values: 0 is the receive register, 1 is the transmit register, 2 is the status register and 3 returns 0x00. MISO sends 0x00 while the command byte is being shifted. Each data byte is captured from the selected register at the start of that byte.
- R4: A data byte written to address 0 replaces the receive register and sets Receive Ready. Data bytes written to addresses 1, 2 or 3 are discarded.
- R5: The status byte holds Transmit Ready in bit 0, Receive Ready in bit 1 and Receive Overrun in bit 2. Bits 7 to 3 read as 0.
- R6: Receive Overrun is set when a byte is written to the receive register while Receive Ready is already set.
- R7: A pulse on the receive acknowledge input clears both Receive Ready and Receive Overrun.
- R8: Transmit Ready is 1 after reset. A transmit load clears it. It is set again when a data byte read from address 1 has been fully shifted out.
- R9: Each interrupt output gives a one-cycle pulse on every 0-to-1 change of its flag. No pulse occurs out of reset.
- R10: With CPHA=0, a bit is sampled on the first SCLK edge of its period and the next bit is driven on the second edge. The first bit is driven when select falls. With CPHA=1, a bit is driven on the first edge and sampled on the second. CPOL=0 means SCLK idles low, and CPOL=1 means it idles high.
- R11: Every data byte in one transaction applies the same write and read addresses again, so receive writes and transmit reads repeat for each byte.
- R12: After reset the flags are Transmit Ready 1, Receive Ready 0 and Overrun 0. The receive data is 0x00 and the MISO enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk_i | input | 1 | Serial clock from master |
| spi_csn_i | input | 1 | Active-low slave select |
| spi_mosi_i | input | 1 | Serial data from master |
| spi_miso_o | output | 1 | Serial data to master |
| spi_miso_oe_o | output | 1 | MISO driver enable, high during a transaction |
| rx_data_o | output | 8 | Receive register contents |
| rx_ack_i | input | 1 | Receive acknowledge pulse |
| tx_data_i | input | 8 | Byte to load into the transmit register |
| tx_load_i | input | 1 | Transmit load strobe |
| stat_tx_ready_o | output | 1 | Transmit Ready flag |
| stat_rx_ready_o | output | 1 | Receive Ready flag |
| stat_overrun_o | output | 1 | Receive Overrun flag |
| irq_tx_ready_o | output | 1 | Pulse when Transmit Ready rises |
| irq_rx_ready_o | output | 1 | Pulse when Receive Ready rises |
| irq_overrun_o | output | 1 | Pulse when Receive Overrun rises |

## Verification
The assertions assume that each SCLK level lasts several system clocks, that select changes only while SCLK is at its idle level, and that MOSI stays stable across each sample edge. The bench acts as the master and meets these assumptions: each SCLK half period is eight system clocks, and it moves SCLK to the idle level of the chosen mode before it lowers select. It drives MOSI only on the edge where the mode drives data, and it reads MISO just before the edge where the mode samples. It drives the user-side strobes only between transactions.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
    localparam int DATA_W = 8;
    localparam int CNT_W  = $clog2(DATA_W);
    localparam int ADDR_W = 2;

    // command field positions
    localparam int WR_LSB = 4;
    localparam int RD_LSB = 2;

    // register addresses
    localparam logic [ADDR_W-1:0] REG_RX   = 2'd0;
    localparam logic [ADDR_W-1:0] REG_TX   = 2'd1;
    localparam logic [ADDR_W-1:0] REG_STAT = 2'd2;

    // status bit positions
    localparam int STAT_TXR = 0;
    localparam int STAT_RXR = 1;
    localparam int STAT_OVR = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_DATA = 2'd2
    } xfer_state_e;
endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync #(
    parameter bit CPOL   = 1'b0,
    parameter bit CPHA   = 1'b0,
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic csn_i,
    input  logic mosi_i,
    output logic csn_s_o,
    output logic mosi_s_o,
    output logic sample_o,
    output logic shift_o
);
    // pipe layout per stage: {sclk, csn, mosi}
    localparam logic [2:0] RST_VAL = {CPOL, 1'b1, 1'b0};

    logic [STAGES-1:0][2:0] pipe_q;
    logic sclk_s, sclk_d_q;
    logic rise, fall, lead, trail;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) pipe_q[s] <= RST_VAL;
            sclk_d_q <= CPOL;
        end else begin
            pipe_q[0] <= {sclk_i, csn_i, mosi_i};
            for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
            sclk_d_q <= sclk_s;
        end
    end

    assign sclk_s   = pipe_q[STAGES-1][2];
    assign csn_s_o  = pipe_q[STAGES-1][1];
    assign mosi_s_o = pipe_q[STAGES-1][0];

    assign rise = sclk_s & ~sclk_d_q & ~csn_s_o;
    assign fall = ~sclk_s & sclk_d_q & ~csn_s_o;

    generate
        if (CPOL == 1'b0) begin : g_pol0
            assign lead  = rise;
            assign trail = fall;
        end else begin : g_pol1
            assign lead  = fall;
            assign trail = rise;
        end
        if (CPHA == 1'b0) begin : g_pha0
            assign sample_o = lead;
            assign shift_o  = trail;
        end else begin : g_pha1
            assign sample_o = trail;
            assign shift_o  = lead;
        end
    endgenerate
endmodule

// File: rtl/spi_cmd_fsm.sv
module spi_cmd_fsm
    import spi_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csn_s_i,
    input  logic              mosi_s_i,
    input  logic              sample_i,
    input  logic              shift_i,
    input  logic [DATA_W-1:0] rd_value_i,
    output logic              miso_o,
    output logic              miso_oe_o,
    output logic              byte_stb_o,
    output logic [DATA_W-1:0] byte_val_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              tx_pull_o
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    xfer_state_e       state_q, state_d;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic [DATA_W-1:0] rx_sh_q, tx_sh_q, byte_full;
    logic [ADDR_W-1:0] wr_q, rd_q;
    logic              byte_end;

    assign byte_full = {rx_sh_q[DATA_W-2:0], mosi_s_i};
    assign byte_end  = sample_i && (bit_cnt_q == LAST_BIT);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (!csn_s_i) state_d = ST_CMD;
            ST_CMD: begin
                if (csn_s_i)       state_d = ST_IDLE;
                else if (byte_end) state_d = ST_DATA;
            end
            ST_DATA: if (csn_s_i) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // shift registers and command capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            rx_sh_q   <= '0;
            tx_sh_q   <= '0;
            wr_q      <= '0;
            rd_q      <= '0;
        end else if (state_q == ST_IDLE) begin
            bit_cnt_q <= '0;
            rx_sh_q   <= '0;
            tx_sh_q   <= '0;
        end else if (!csn_s_i) begin
            if (sample_i) begin
                rx_sh_q   <= byte_full;
                bit_cnt_q <= bit_cnt_q + 1'b1;
                if (byte_end && state_q == ST_CMD) begin
                    wr_q <= byte_full[WR_LSB +: ADDR_W];
                    rd_q <= byte_full[RD_LSB +: ADDR_W];
                end
            end
            if (shift_i) begin
                if (bit_cnt_q == '0)
                    tx_sh_q <= (state_q == ST_DATA) ? rd_value_i : '0;
                else
                    tx_sh_q <= {tx_sh_q[DATA_W-2:0], 1'b0};
            end
        end
    end

    // outputs
    always_comb begin
        miso_oe_o  = (state_q != ST_IDLE);
        miso_o     = miso_oe_o & tx_sh_q[DATA_W-1];
        byte_stb_o = byte_end && (state_q == ST_DATA) && !csn_s_i;
        byte_val_o = byte_full;
        wr_addr_o  = wr_q;
        rd_addr_o  = rd_q;
        tx_pull_o  = shift_i && (bit_cnt_q == '0) && (state_q == ST_DATA)
                     && (rd_q == REG_TX) && !csn_s_i;
    end

    AST_SEL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && csn_s_i) |=> (state_q == ST_IDLE && !miso_oe_o))
        else $error("select release did not end transfer"); // R1
    AST_CMD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> (state_q != ST_DATA))
        else $error("data phase entered without command"); // R2
endmodule

// File: rtl/spi_cmd_regfile.sv
module spi_cmd_regfile
    import spi_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_stb_i,
    input  logic [DATA_W-1:0] byte_val_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic              tx_pull_i,
    input  logic              active_i,
    input  logic              rx_ack_i,
    input  logic              tx_load_i,
    input  logic [DATA_W-1:0] tx_data_i,
    output logic [DATA_W-1:0] rx_data_o,
    output logic [DATA_W-1:0] rd_value_o,
    output logic              tx_rdy_o,
    output logic              rx_rdy_o,
    output logic              ovr_o,
    output logic              irq_tx_o,
    output logic              irq_rx_o,
    output logic              irq_ovr_o
);
    logic [DATA_W-1:0] rx_q, tx_q, status;
    logic              rx_rdy_q, ovr_q, tx_rdy_q, inflight_q;
    logic [2:0]        flags_d_q;
    logic              rx_wr;

    assign rx_wr = byte_stb_i && (wr_addr_i == REG_RX);

    // receive side
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q     <= '0;
            rx_rdy_q <= 1'b0;
            ovr_q    <= 1'b0;
        end else if (rx_wr) begin
            rx_q     <= byte_val_i;
            rx_rdy_q <= 1'b1;
            ovr_q    <= rx_ack_i ? 1'b0 : (ovr_q | rx_rdy_q);
        end else if (rx_ack_i) begin
            rx_rdy_q <= 1'b0;
            ovr_q    <= 1'b0;
        end
    end

    // transmit side
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q       <= '0;
            tx_rdy_q   <= 1'b1;
            inflight_q <= 1'b0;
        end else if (tx_load_i) begin
            tx_q       <= tx_data_i;
            tx_rdy_q   <= 1'b0;
            inflight_q <= 1'b0;
        end else if (!active_i) begin
            inflight_q <= 1'b0;
        end else if (byte_stb_i && inflight_q) begin
            tx_rdy_q   <= 1'b1;
            inflight_q <= 1'b0;
        end else if (tx_pull_i) begin
            inflight_q <= 1'b1;
        end
    end

    // interrupt edge detect, order {ovr, rx, tx}
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_d_q <= 3'b001;
        else        flags_d_q <= {ovr_q, rx_rdy_q, tx_rdy_q};
    end

    always_comb begin
        status           = '0;
        status[STAT_TXR] = tx_rdy_q;
        status[STAT_RXR] = rx_rdy_q;
        status[STAT_OVR] = ovr_q;
        unique case (rd_addr_i)
            REG_RX:   rd_value_o = rx_q;
            REG_TX:   rd_value_o = tx_q;
            REG_STAT: rd_value_o = status;
            default:  rd_value_o = '0;
        endcase
    end

    assign rx_data_o = rx_q;
    assign tx_rdy_o  = tx_rdy_q;
    assign rx_rdy_o  = rx_rdy_q;
    assign ovr_o     = ovr_q;
    assign irq_tx_o  = tx_rdy_q & ~flags_d_q[0];
    assign irq_rx_o  = rx_rdy_q & ~flags_d_q[1];
    assign irq_ovr_o = ovr_q    & ~flags_d_q[2];

    AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_q) |-> $past(rx_rdy_q))
        else $error("overrun without pending byte"); // R6
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ack_i && !rx_wr) |=> (!rx_rdy_q && !ovr_q))
        else $error("acknowledge left flags set"); // R7
    AST_TX_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load_i |=> !tx_rdy_q)
        else $error("transmit ready after load"); // R8
    AST_TX_SENT: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stb_i && inflight_q && active_i && !tx_load_i) |=> tx_rdy_q)
        else $error("transmit ready not restored"); // R8
endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
    import spi_cmd_pkg::*;
#(
    parameter bit CPOL        = 1'b0,
    parameter bit CPHA        = 1'b0,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk_i,
    input  logic              spi_csn_i,
    input  logic              spi_mosi_i,
    output logic              spi_miso_o,
    output logic              spi_miso_oe_o,
    output logic [DATA_W-1:0] rx_data_o,
    input  logic              rx_ack_i,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              tx_load_i,
    output logic              stat_tx_ready_o,
    output logic              stat_rx_ready_o,
    output logic              stat_overrun_o,
    output logic              irq_tx_ready_o,
    output logic              irq_rx_ready_o,
    output logic              irq_overrun_o
);
    logic              csn_s, mosi_s, sample_stb, shift_stb;
    logic              byte_stb, tx_pull;
    logic [DATA_W-1:0] byte_val, rd_value;
    logic [ADDR_W-1:0] wr_addr, rd_addr;

    spi_cmd_sync #(
        .CPOL   (CPOL),
        .CPHA   (CPHA),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_i   (spi_sclk_i),
        .csn_i    (spi_csn_i),
        .mosi_i   (spi_mosi_i),
        .csn_s_o  (csn_s),
        .mosi_s_o (mosi_s),
        .sample_o (sample_stb),
        .shift_o  (shift_stb)
    );

    spi_cmd_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .csn_s_i    (csn_s),
        .mosi_s_i   (mosi_s),
        .sample_i   (sample_stb),
        .shift_i    (shift_stb),
        .rd_value_i (rd_value),
        .miso_o     (spi_miso_o),
        .miso_oe_o  (spi_miso_oe_o),
        .byte_stb_o (byte_stb),
        .byte_val_o (byte_val),
        .wr_addr_o  (wr_addr),
        .rd_addr_o  (rd_addr),
        .tx_pull_o  (tx_pull)
    );

    spi_cmd_regfile u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_stb_i (byte_stb),
        .byte_val_i (byte_val),
        .wr_addr_i  (wr_addr),
        .rd_addr_i  (rd_addr),
        .tx_pull_i  (tx_pull),
        .active_i   (spi_miso_oe_o),
        .rx_ack_i   (rx_ack_i),
        .tx_load_i  (tx_load_i),
        .tx_data_i  (tx_data_i),
        .rx_data_o  (rx_data_o),
        .rd_value_o (rd_value),
        .tx_rdy_o   (stat_tx_ready_o),
        .rx_rdy_o   (stat_rx_ready_o),
        .ovr_o      (stat_overrun_o),
        .irq_tx_o   (irq_tx_ready_o),
        .irq_rx_o   (irq_rx_ready_o),
        .irq_ovr_o  (irq_overrun_o)
    );
endmodule

// File: tb/spi_cmd_regs_tb_top.sv
module spi_cmd_regs_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_SCK   = 8;
    localparam int WDOG_CYC   = 150000;

    typedef struct packed {
        logic [7:0] cmd;
        logic [7:0] mosi;
        logic [7:0] miso;
        logic [7:0] rx;
        logic       rxr;
        logic       ovr;
        logic       txr;
        logic       ack;
    } vec_t;

    // write addr in cmd[5:4], read addr in cmd[3:2]; status bit0 txr, bit1 rxr, bit2 ovr
    localparam vec_t VECS [0:6] = '{
        '{8'h08, 8'h3C, 8'h00, 8'h3C, 1'b1, 1'b0, 1'b0, 1'b0},
        '{8'h00, 8'h5A, 8'h3C, 8'h5A, 1'b1, 1'b1, 1'b0, 1'b1},
        '{8'h34, 8'hFF, 8'hA5, 8'h5A, 1'b0, 1'b0, 1'b1, 1'b0},
        '{8'h2C, 8'h77, 8'h00, 8'h5A, 1'b0, 1'b0, 1'b1, 1'b0},
        '{8'hC9, 8'h81, 8'h01, 8'h81, 1'b1, 1'b0, 1'b1, 1'b0},
        '{8'h10, 8'h42, 8'h81, 8'h81, 1'b1, 1'b0, 1'b1, 1'b0},
        '{8'h34, 8'h00, 8'hA5, 8'h81, 1'b1, 1'b0, 1'b1, 1'b0}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic sclk = 1'b0, mosi = 1'b0, csn0 = 1'b1, csn3 = 1'b1, sel3 = 1'b0;
    logic rx_ack0 = 1'b0, tx_load0 = 1'b0, rx_ack3 = 1'b0, tx_load3 = 1'b0;
    logic [7:0] tx_data0 = '0, tx_data3 = '0;
    logic miso0, oe0, miso3, oe3, miso_sel;
    logic [7:0] rx0, rx3;
    logic txr0, rxr0, ovr0, itx0, irx0, iovr0;
    logic txr3, rxr3, ovr3, itx3, irx3, iovr3;
    logic [7:0] mo [0:3];
    logic [7:0] mi [0:3];
    int n_chk = 0, n_bad = 0;
    int cnt_itx = 0, cnt_irx = 0, cnt_iovr = 0;
    bit oe_seen = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign miso_sel = sel3 ? miso3 : miso0;

    spi_cmd_regs dut_i (
        .clk(clk), .rst_n(rst_n), .spi_sclk_i(sclk), .spi_csn_i(csn0), .spi_mosi_i(mosi),
        .spi_miso_o(miso0), .spi_miso_oe_o(oe0), .rx_data_o(rx0), .rx_ack_i(rx_ack0),
        .tx_data_i(tx_data0), .tx_load_i(tx_load0), .stat_tx_ready_o(txr0),
        .stat_rx_ready_o(rxr0), .stat_overrun_o(ovr0), .irq_tx_ready_o(itx0),
        .irq_rx_ready_o(irx0), .irq_overrun_o(iovr0));

    spi_cmd_regs #(.CPOL(1'b1), .CPHA(1'b1)) dut_m3 (
        .clk(clk), .rst_n(rst_n), .spi_sclk_i(sclk), .spi_csn_i(csn3), .spi_mosi_i(mosi),
        .spi_miso_o(miso3), .spi_miso_oe_o(oe3), .rx_data_o(rx3), .rx_ack_i(rx_ack3),
        .tx_data_i(tx_data3), .tx_load_i(tx_load3), .stat_tx_ready_o(txr3),
        .stat_rx_ready_o(rxr3), .stat_overrun_o(ovr3), .irq_tx_ready_o(itx3),
        .irq_rx_ready_o(irx3), .irq_overrun_o(iovr3));

    always @(negedge clk) begin
        if (itx0)  cnt_itx++;
        if (irx0)  cnt_irx++;
        if (iovr0) cnt_iovr++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load_tx(input bit m3, input logic [7:0] d);
        if (m3) begin tx_data3 = d; tx_load3 = 1'b1; end
        else    begin tx_data0 = d; tx_load0 = 1'b1; end
        wait_clk(1);
        tx_load0 = 1'b0; tx_load3 = 1'b0;
        wait_clk(2);
    endtask

    task automatic ack_rx(input bit m3);
        if (m3) rx_ack3 = 1'b1; else rx_ack0 = 1'b1;
        wait_clk(1);
        rx_ack0 = 1'b0; rx_ack3 = 1'b0;
        wait_clk(2);
    endtask

    // master: mode bit1 = CPOL, bit0 = CPHA; mode 0 talks to dut_i, mode 3 to dut_m3
    task automatic xfer(input int mode, input int nbytes);
        bit cpol = mode[1];
        bit cpha = mode[0];
        sel3 = (mode == 3);
        sclk = cpol;
        wait_clk(2*HALF_SCK);
        if (!cpha) mosi = mo[0][7];
        if (sel3) csn3 = 1'b0; else csn0 = 1'b0;
        wait_clk(HALF_SCK);
        for (int k = 0; k < nbytes; k++) begin
            for (int i = 7; i >= 0; i--) begin
                if (!cpha) begin
                    mi[k][i] = miso_sel;
                    sclk = ~sclk;
                    wait_clk(HALF_SCK);
                    sclk = ~sclk;
                    if (i > 0) mosi = mo[k][i-1];
                    else if (k + 1 < nbytes) mosi = mo[k+1][7];
                    wait_clk(HALF_SCK);
                end else begin
                    sclk = ~sclk;
                    mosi = mo[k][i];
                    wait_clk(HALF_SCK);
                    mi[k][i] = miso_sel;
                    sclk = ~sclk;
                    wait_clk(HALF_SCK);
                end
            end
        end
        csn0 = 1'b1; csn3 = 1'b1;
        wait_clk(4*HALF_SCK);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);

        // R12 reset state
        chk("R12 txr", txr0, 1);
        chk("R12 rxr", rxr0, 0);
        chk("R12 ovr", ovr0, 0);
        chk("R12 rx_data", rx0, 8'h00);
        chk("R12 miso_oe", oe0, 0);

        // R1 clocks and data with select high are ignored
        for (int t = 0; t < 24; t++) begin
            sclk = ~sclk; mosi = t[0];
            wait_clk(HALF_SCK);
            if (oe0 || oe3) oe_seen = 1'b1;
        end
        sclk = 1'b0;
        wait_clk(4*HALF_SCK);
        chk("R1 no oe", oe_seen, 0);
        chk("R1 miso low", miso0, 0);
        chk("R1 rxr unchanged", rxr0, 0);
        chk("R1 rx unchanged", rx0, 8'h00);

        load_tx(1'b0, 8'hA5);
        chk("R8 load clears txr", txr0, 0);

        // vector table, mode 0
        for (int v = 0; v < 7; v++) begin
            mo[0] = VECS[v].cmd;
            mo[1] = VECS[v].mosi;
            xfer(0, 2);
            chk("R3 cmd phase miso", mi[0], 8'h00);
            chk("R2 R3 R5 data miso", mi[1], VECS[v].miso);
            chk("R4 rx data", rx0, VECS[v].rx);
            chk("R4 rx ready", rxr0, VECS[v].rxr);
            chk("R6 R7 overrun", ovr0, VECS[v].ovr);
            chk("R8 tx ready", txr0, VECS[v].txr);
            if (VECS[v].ack) ack_rx(1'b0);
        end

        // R9 interrupt pulse counts
        chk("R9 irq tx pulses", cnt_itx, 1);
        chk("R9 irq rx pulses", cnt_irx, 2);
        chk("R9 irq ovr pulses", cnt_iovr, 1);

        // R11 multi-byte transaction: write rx, read tx
        ack_rx(1'b0);
        chk("R7 ack clears rxr", rxr0, 0);
        load_tx(1'b0, 8'h3E);
        mo[0] = 8'h04; mo[1] = 8'h11; mo[2] = 8'h22;
        xfer(0, 3);
        chk("R11 byte1 miso", mi[1], 8'h3E);
        chk("R11 byte2 miso", mi[2], 8'h3E);
        chk("R11 rx last", rx0, 8'h22);
        chk("R11 R6 overrun", ovr0, 1);
        chk("R11 R8 txr", txr0, 1);
        chk("R9 irq tx total", cnt_itx, 2);
        chk("R9 irq ovr total", cnt_iovr, 2);

        // R10 mode 3 instance
        chk("R12 m3 txr", txr3, 1);
        load_tx(1'b1, 8'h96);
        mo[0] = 8'h04; mo[1] = 8'hC3;
        xfer(3, 2);
        chk("R10 m3 cmd miso", mi[0], 8'h00);
        chk("R10 m3 data miso", mi[1], 8'h96);
        chk("R10 m3 rx", rx3, 8'hC3);
        chk("R10 m3 rxr", rxr3, 1);
        chk("R10 m3 ovr", ovr3, 0);
        chk("R10 m3 txr", txr3, 1);
        chk("R1 m0 untouched by m3", rx0, 8'h22);

        finish_run();
    end
endmodule